// File: doc/BRIEF.md
# FIFO-Fed Parallel Strobe Writer

This block is a master-side sequencer. It takes words from the read side of an internal FIFO and presents each one on a parallel output bus. It then produces one rising-edge write strobe per word, so that a slave can capture the words, for example a stream of configuration data. The strobe rests high. For each word the machine puts the word on the bus and pulls the strobe low for one full clock, which gives the receiver its setup time. It then raises the strobe while the bus keeps the same value. Only after that does it remove the word from the FIFO, in a separate step.

Putting the head word on the bus and popping the FIFO are two separate actions. The bus reloads from the FIFO head on every clock of the setup and strobe states. Because no pop happens in those states, the head word is the same on each reload. The remove state comes next and lasts a programmable number of clocks. By default it pops once, on entry. With the repeat option set, it pops on every clock it is held, and the words popped after the first are consumed without being strobed. The machine counts strobed words and stops with a done flag when a programmed count is reached. Dropping the enable returns it to its start state, which clears the flag and the count.

Top module: `strobe_writer`

## Requirements
- R1: In reset, `strobe` is 1, `bus_data` is 0, and `fifo_pop` and `done` are 0.
- R2: While `enable` is 0, no pop is issued and `strobe` stays high, even if the FIFO holds data.
- R3: Before each rising edge of `strobe`, the strobe is low for exactly one clock. During that clock `bus_data` already carries the FIFO head word that is about to be strobed.
- R4: `bus_data` has the same value in the low clock, in the clock where `strobe` has risen, and in the clock after that.
- R5: `fifo_pop` is never asserted while `strobe` is low, nor in the clock where `strobe` has just risen. The first pop comes in the clock after the strobe clock.
- R6: With `repeat_pop` = 0, each strobed word is popped exactly once, however long the remove state lasts (`rm_len` clocks, where 0 is treated as 1). Consecutive strobes therefore carry consecutive FIFO words.
- R7: With `repeat_pop` = 1, a pop is issued on every clock of the remove state. Each strobed word therefore consumes `rm_len` FIFO entries, and the next word strobed is the one `rm_len` entries further on.
- R8: `fifo_pop` is never asserted while `fifo_valid` is 0.
- R9: While the FIFO is empty, the machine waits with `strobe` high and `bus_data` holding its last value. A new word starts only after `fifo_valid` has been seen high.
- R10: When `word_count` is nonzero, `done` rises once that many words have been strobed. After that, no further strobe or pop happens while `enable` stays high. A `word_count` of 0 means no limit.
- R11: Dropping `enable` returns the machine to its start state, which clears `done`. The next enable starts counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Start/run request |
| repeat_pop | input | 1 | 1: pop on every remove-state clock; 0: pop once |
| rm_len | input | RW (4) | Remove-state length in clocks (0 acts as 1) |
| word_count | input | CW (16) | Words to strobe before done; 0 = unlimited |
| fifo_data | input | DW (32) | FIFO head word |
| fifo_valid | input | 1 | FIFO not empty |
| fifo_pop | output | 1 | Remove head word at this clock edge |
| bus_data | output | DW (32) | Parallel data bus to slave |
| strobe | output | 1 | Write strobe, slave captures on rising edge |
| done | output | 1 | Programmed word count reached |

## Verification
The bound checker checks the strobe timing on every cycle. It verifies the single low clock before each rise, that the bus stays stable across the rise and the clock after it, that no pop occurs while the strobe is low or rising, that no pop occurs on an empty FIFO, that a strobe falls only after data was valid, and that the machine stays quiet while done is high. Other behaviours span many cycles and are left to the bench scenarios. These are which FIFO word appears at each strobe, how many entries each word consumes with and without the repeat option, when done is reached, and the restart of the count after enable is dropped.

// File: rtl/sw_pkg.sv
package sw_pkg;
    typedef enum logic [2:0] {
        SW_START  = 3'd0,
        SW_IDLE   = 3'd1,
        SW_SETUP  = 3'd2,
        SW_STROBE = 3'd3,
        SW_REMOVE = 3'd4
    } sw_state_e;
endpackage

// File: rtl/sw_word_counter.sv
module sw_word_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/sw_bus_reg.sv
module sw_bus_reg #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] bus_d, bus_q;

    // Reloads every clock it is told to; holds otherwise.
    always_comb begin
        bus_d = load ? din : bus_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign dout = bus_q;
endmodule

// File: rtl/sw_seq.sv
module sw_seq
    import sw_pkg::*;
#(
    parameter int CW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          fifo_valid,
    input  logic          repeat_pop,
    input  logic [RW-1:0] rm_len,
    input  logic [CW-1:0] word_count,
    input  logic [CW-1:0] cnt,
    output logic          bus_load,
    output logic          cnt_clr,
    output logic          cnt_inc,
    output logic          strobe,
    output logic          pop_req,
    output logic          done
);
    typedef struct packed {
        sw_state_e     st;
        logic [RW-1:0] rm;
        logic          strobe;
        logic          pop;
        logic          done;
    } seq_t;

    seq_t r_q, r_d;
    logic [RW:0] eff_len;
    logic [RW:0] rm_next;

    assign eff_len = (rm_len == '0) ? {{RW{1'b0}}, 1'b1} : {1'b0, rm_len};
    assign rm_next = {1'b0, r_q.rm} + 1'b1;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SW_START: begin
                r_d.done = 1'b0;
                if (enable) r_d.st = SW_IDLE;
            end
            SW_IDLE: begin
                if (!enable)
                    r_d.st = SW_START;
                else if (!r_q.done && fifo_valid)
                    r_d.st = SW_SETUP;
            end
            SW_SETUP: begin
                r_d.st = SW_STROBE;
            end
            SW_STROBE: begin
                r_d.st = SW_REMOVE;
                r_d.rm = '0;
            end
            SW_REMOVE: begin
                if (rm_next >= eff_len) begin
                    r_d.st = SW_IDLE;
                    if (word_count != '0 && cnt >= word_count)
                        r_d.done = 1'b1;
                end else begin
                    r_d.rm = rm_next[RW-1:0];
                end
            end
            default: r_d.st = SW_START;
        endcase
        r_d.strobe = (r_d.st != SW_SETUP);
        r_d.pop    = (r_d.st == SW_REMOVE) && ((r_q.st == SW_STROBE) || repeat_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= SW_START;
            r_q.rm     <= '0;
            r_q.strobe <= 1'b1;
            r_q.pop    <= 1'b0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_load = (r_d.st == SW_SETUP) || (r_d.st == SW_STROBE);
    assign cnt_clr  = (r_q.st == SW_START) && enable;
    assign cnt_inc  = (r_q.st == SW_STROBE);
    assign strobe   = r_q.strobe;
    assign pop_req  = r_q.pop;
    assign done     = r_q.done;
endmodule

// File: rtl/strobe_writer.sv
module strobe_writer #(
    parameter int DW = 32,
    parameter int CW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          repeat_pop,
    input  logic [RW-1:0] rm_len,
    input  logic [CW-1:0] word_count,
    input  logic [DW-1:0] fifo_data,
    input  logic          fifo_valid,
    output logic          fifo_pop,
    output logic [DW-1:0] bus_data,
    output logic          strobe,
    output logic          done
);
    logic          bus_load;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          pop_req;
    logic [CW-1:0] cnt;

    sw_seq #(.CW(CW), .RW(RW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .fifo_valid (fifo_valid),
        .repeat_pop (repeat_pop),
        .rm_len     (rm_len),
        .word_count (word_count),
        .cnt        (cnt),
        .bus_load   (bus_load),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .strobe     (strobe),
        .pop_req    (pop_req),
        .done       (done)
    );

    sw_word_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    sw_bus_reg #(.DW(DW)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bus_load),
        .din   (fifo_data),
        .dout  (bus_data)
    );

    // Never pop an empty source, even in repeat mode.
    assign fifo_pop = pop_req && fifo_valid;
endmodule

// File: rtl/strobe_writer_chk.sv
module strobe_writer_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          fifo_valid,
    input logic          fifo_pop,
    input logic [DW-1:0] bus_data,
    input logic          strobe,
    input logic          done
);
    // R3: low phase lasts exactly one clock
    assert_low_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |=> $rose(strobe));

    // R4: bus unchanged across the rising edge and the following clock
    assert_bus_at_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $stable(bus_data));
    assert_bus_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |=> $stable(bus_data));

    // R5: no pop while low or in the rising clock
    assert_no_pop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> !fifo_pop);
    assert_no_pop_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> !fifo_pop);

    // R8: never pop an empty FIFO
    assert_no_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> fifo_valid);

    // R9: a new word starts only after data was valid
    assert_start_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> $past(fifo_valid));

    // R10: quiet while done
    assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (strobe && !fifo_pop));

    // R2: nothing happens while disabled and settled
    assert_idle_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable) && !done && strobe) |-> !fifo_pop);
endmodule

bind strobe_writer strobe_writer_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .fifo_valid (fifo_valid),
    .fifo_pop   (fifo_pop),
    .bus_data   (bus_data),
    .strobe     (strobe),
    .done       (done)
);

// File: tb/sim_strobe_writer.sv
`timescale 1ns/1ps
module sim_strobe_writer;
    localparam int DW = 32;
    localparam int CW = 16;
    localparam int RW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          repeat_pop = 1'b0;
    logic [RW-1:0] rm_len = 4'd1;
    logic [CW-1:0] word_count = '0;
    logic [DW-1:0] fifo_data;
    logic          fifo_valid;
    logic          fifo_pop;
    logic [DW-1:0] bus_data;
    logic          strobe;
    logic          done;

    always #5 clk = ~clk;

    // Bench-side source FIFO
    logic [DW-1:0] mem [256];
    logic [7:0]    rd = 8'd0;
    logic [7:0]    wr = 8'd0;
    assign fifo_valid = (wr != rd);
    assign fifo_data  = mem[rd];
    always @(posedge clk) if (fifo_pop) rd <= rd + 8'd1;

    strobe_writer #(.DW(DW), .CW(CW), .RW(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .repeat_pop(repeat_pop),
        .rm_len(rm_len), .word_count(word_count), .fifo_data(fifo_data),
        .fifo_valid(fifo_valid), .fifo_pop(fifo_pop), .bus_data(bus_data),
        .strobe(strobe), .done(done));

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int step = 1;
    logic [7:0] exp_idx = 8'd0;
    logic monitor_on = 1'b0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] v);
        mem[wr] = v;
        wr = wr + 8'd1;
    endtask

    function automatic logic [7:0] consumed(input int words, input int len, input logic rep);
        int l = (len == 0) ? 1 : len;
        return 8'(rep ? words * l : words);
    endfunction

    // Monitor: sampled at the falling edge
    logic          p_strobe = 1'b1;
    logic          p_valid = 1'b0;
    logic [DW-1:0] p_bus = '0;
    logic          p_rise = 1'b0;
    always @(negedge clk) begin
        if (monitor_on) begin
            if (!strobe && fifo_pop) chk(1'b0, "R5 pop while low", 1, 0);
            if (!strobe && p_strobe && !p_valid) chk(1'b0, "R9 start on empty", 1, 0);
            if (strobe && !p_strobe) begin
                strobes++;
                chk(bus_data == mem[exp_idx], "R3 word at strobe", bus_data, mem[exp_idx]);
                chk(bus_data == p_bus, "R4 bus stable at rise", bus_data, p_bus);
                chk(!fifo_pop, "R5 no pop at rise", fifo_pop, 0);
                exp_idx = exp_idx + 8'(step);
            end
            if (p_rise) chk(bus_data == p_bus, "R4 bus stable after rise", bus_data, p_bus);
            if (done && fifo_pop) chk(1'b0, "R10 pop while done", 1, 0);
        end
        p_rise   = strobe && !p_strobe;
        p_strobe = strobe;
        p_valid  = fifo_valid;
        p_bus    = bus_data;
    end

    task automatic wait_done(input string req);
        int i = 0;
        while (!done && i < 2000) begin @(negedge clk); i++; end
        chk(done, req, done, 1);
    endtask

    task automatic drop_enable();
        enable = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [7:0] r0;
        int s0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(strobe == 1'b1, "R1 strobe", strobe, 1);
        chk(bus_data == '0, "R1 bus", bus_data, 0);
        chk(fifo_pop == 1'b0, "R1 pop", fifo_pop, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        rst_n = 1'b1;
        monitor_on = 1'b1;

        // R2: data present, enable low
        for (int k = 0; k < 8; k++) push($urandom);
        repeat (20) @(negedge clk);
        chk(rd == 8'd0, "R2 no pop while disabled", rd, 0);
        chk(strobes == 0, "R2 no strobe while disabled", strobes, 0);

        // R6: unlimited, single pop, consecutive words
        word_count = '0; rm_len = 4'd1; repeat_pop = 1'b0; step = 1; exp_idx = rd;
        enable = 1'b1;
        for (int i = 0; i < 500 && rd != wr; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(strobes == 8, "R6 strobe count", strobes, 8);
        chk(rd == 8'd8, "R6 one pop per word", rd, 8);
        // R9: empty, bus holds the last word
        chk(strobe == 1'b1, "R9 strobe high when empty", strobe, 1);
        chk(bus_data == mem[7], "R9 bus holds last word", bus_data, mem[7]);
        drop_enable();

        // R7/R10: repeat mode, 3 pops per word, stop after 4 words
        r0 = rd; s0 = strobes;
        for (int k = 0; k < 12; k++) push($urandom);
        word_count = 16'd4; rm_len = 4'd3; repeat_pop = 1'b1; step = 3; exp_idx = rd;
        enable = 1'b1;
        wait_done("R10 done after count");
        chk(strobes - s0 == 4, "R10 strobe count", strobes - s0, 4);
        chk(rd - r0 == consumed(4, 3, 1'b1), "R7 entries consumed", rd - r0, consumed(4, 3, 1'b1));

        // R10: no activity while done even with new data
        r0 = rd; s0 = strobes;
        for (int k = 0; k < 3; k++) push($urandom);
        repeat (30) @(negedge clk);
        chk(rd == r0, "R10 no pop while done", rd, r0);
        chk(strobes == s0, "R10 no strobe while done", strobes, s0);

        // R11: drop enable clears done, count restarts
        drop_enable();
        chk(done == 1'b0, "R11 done cleared", done, 0);
        word_count = 16'd2; rm_len = 4'd1; repeat_pop = 1'b0; step = 1; exp_idx = rd;
        enable = 1'b1;
        wait_done("R11 done after restart");
        chk(strobes - s0 == 2, "R11 count restarted", strobes - s0, 2);
        chk(rd - r0 == 8'd2, "R11 pops", rd - r0, 2);
        drop_enable();

        // R6/R9: trickle feed with gaps, long remove state, pop once
        r0 = rd; s0 = strobes;
        word_count = 16'd10; rm_len = 4'd2; repeat_pop = 1'b0; step = 1; exp_idx = rd;
        enable = 1'b1;
        for (int k = 0; k < 11; k++) begin
            repeat ($urandom_range(0, 7)) @(negedge clk);
            push($urandom);
        end
        wait_done("R10 done in trickle");
        chk(strobes - s0 == 10, "R6 trickle strobes", strobes - s0, 10);
        chk(rd - r0 == consumed(10, 2, 1'b0), "R6 trickle pops", rd - r0, consumed(10, 2, 1'b0));
        drop_enable();

        // R7/R8: repeat with too few entries, never pops empty
        r0 = rd; s0 = strobes;
        push($urandom); push($urandom);
        word_count = 16'd1; rm_len = 4'd5; repeat_pop = 1'b1; step = 5; exp_idx = rd;
        enable = 1'b1;
        wait_done("R10 done short source");
        chk(rd == wr, "R8 stops at empty", rd, wr);
        chk(strobes - s0 == 1, "R7 single strobe", strobes - s0, 1);
        drop_enable();
        summary();
    end
endmodule